// File: doc/BRIEF.md
# SMBus Host Controller Register Window

This block is the byte-wide register window that host software uses to drive an SMBus host controller. It decodes single-byte reads and writes in a 16-byte space. It holds the target address, the command byte, two data bytes, the control byte and a sticky status byte. A 32-byte block buffer sits behind one data port, and that port advances an internal index on every access. The block also drives a level-sensitive interrupt line.

Software starts a transaction by writing the control byte with its start bit set. The block then gives a one-cycle start pulse to a separate bus sequencer and exposes the latched registers to it. The sequencer later returns a done pulse with an error flag. In the same cycle or earlier, it may write results into the data bytes and the buffer through its own strobes. The block does not generate SMBus wire traffic.

Top module: `smbHostRegs`

## Requirements
- R1: After reset, every defined register reads 0x00 and the interrupt output is low.
- R2: Reads return the target address at offset 0x4, data byte 0 at 0x6, data byte 1 at 0x7 and the command at 0x8, each holding the last value written to it. Offsets with no register (for example 0x1, 0x3, 0xF) read 0x00.
- R3: The control byte at offset 0x2 reads back only bits [4:0]: cycle type [2:0], start bit 3 and interrupt enable bit 4. The cycle type is also driven to the sequencer.
- R4: Writing the control byte with bit 5 set sets status bit 0 (abort).
- R5: A control write with bit 3 set while idle gives a start pulse exactly one cycle wide in the cycle after the write. Status bit 3 (busy) reads 1 from that cycle until the sequencer's done pulse has been taken.
- R6: A control write with bit 3 set while busy gives no start pulse.
- R7: A done pulse clears busy. It sets status bit 4 (cycle complete) when the error flag is low and status bit 2 (protocol error) when the flag is high.
- R8: On a done pulse, the interrupt goes high in the next cycle when control bit 4 is set and any of status bits {0,1,2,4,5} is set. Otherwise it goes low.
- R9: A status write (offset 0x0) whose value has any of bits {0,1,2,4,5} set clears the status register to 0x00. Any other status write loads 0x10. Both kinds return the buffer index to 0.
- R10: On a status write, the interrupt goes high when control bit 4 is set and the written value holds a bit of {0,1,2,4,5} that is not already set in status. Otherwise it goes low.
- R11: Each read or write of the buffer port (offset 0x9) accesses the entry at the current index and then advances the index, which wraps from 31 to 0.
- R12: The sequencer can write data byte 0, data byte 1 and any buffer entry through its strobes, and can read any buffer entry by index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host write strobe |
| regRdEn | input | 1 | Host read strobe; advances the buffer index on a buffer-port read |
| regAddr | input | 4 | Register offset |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| irq | output | 1 | Level interrupt |
| seqStart | output | 1 | One-cycle transaction start pulse |
| seqCycType | output | 3 | Cycle type from control bits [2:0] |
| seqAddr | output | 8 | Target address byte |
| seqCmd | output | 8 | Command byte |
| seqData0 | output | 8 | Data byte 0 |
| seqData1 | output | 8 | Data byte 1 |
| seqDone | input | 1 | Transaction finished pulse |
| seqErr | input | 1 | Error flag qualifying seqDone |
| seqData0We | input | 1 | Sequencer write of data byte 0 |
| seqData0In | input | 8 | Value for data byte 0 |
| seqData1We | input | 1 | Sequencer write of data byte 1 |
| seqData1In | input | 8 | Value for data byte 1 |
| seqBufWe | input | 1 | Sequencer buffer write |
| seqBufIdx | input | 5 | Sequencer buffer index for read and write |
| seqBufWrData | input | 8 | Sequencer buffer write value |
| seqBufRdData | output | 8 | Buffer entry at seqBufIdx |

## Verification
Read data is combinational, so a read check samples regRdData in the same cycle as the address, before the clock edge. Every register, status and interrupt effect of a write or a done pulse is due one edge later. The start pulse appears one edge after the control write and is gone after the next edge. The bench drives inputs on the falling edge and checks just after the rising edge that takes them, so each result is sampled in the first cycle it is due. Buffer-port reads check the entry at the current index before the edge that advances it.

// File: rtl/smbhost_pkg.sv
package smbhost_pkg;
  // register offsets (software view)
  localparam logic [3:0] OFF_STAT = 4'h0;
  localparam logic [3:0] OFF_CTRL = 4'h2;
  localparam logic [3:0] OFF_ADDR = 4'h4;
  localparam logic [3:0] OFF_D0   = 4'h6;
  localparam logic [3:0] OFF_D1   = 4'h7;
  localparam logic [3:0] OFF_CMD  = 4'h8;
  localparam logic [3:0] OFF_BUF  = 4'h9;

  // status bits
  localparam int ST_ABORT = 0;
  localparam int ST_PERR  = 2;
  localparam int ST_BUSY  = 3;
  localparam int ST_DONE  = 4;
  localparam logic [7:0] STAT_CLR_MASK = 8'h37;
  localparam logic [7:0] STAT_FORCED   = 8'h10;

  // control bits
  localparam int CT_START = 3;
  localparam int CT_IEN   = 4;
  localparam int CT_ABORT = 5;
  localparam int CTRL_W   = 5;

  localparam int DEF_BUF_DEPTH = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAddr;
    logic wrCmd;
    logic wrD0;
    logic wrD1;
    logic bufWr;
    logic bufRd;
    logic idxClr;
  } strobes_t;
endpackage

// File: rtl/smbHostCtrl.sv
module smbHostCtrl
  import smbhost_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              seqDone,
  input  logic              seqErr,
  output strobes_t          strb,
  output logic [7:0]        statusVal,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic              seqStart,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [7:0] statReg, nStat;
  logic busy, startQ, irqQ;
  logic wrStat, wrCtrl, launch;

  assign wrStat = regWrEn && (regAddr == OFF_STAT);
  assign wrCtrl = regWrEn && (regAddr == OFF_CTRL);
  assign launch = wrCtrl && regWrData[CT_START] && !busy;

  always_comb begin
    strb.wrAddr = regWrEn && (regAddr == OFF_ADDR);
    strb.wrCmd  = regWrEn && (regAddr == OFF_CMD);
    strb.wrD0   = regWrEn && (regAddr == OFF_D0);
    strb.wrD1   = regWrEn && (regAddr == OFF_D1);
    strb.bufWr  = regWrEn && (regAddr == OFF_BUF);
    strb.bufRd  = regRdEn && !regWrEn && (regAddr == OFF_BUF);
    strb.idxClr = wrStat;
  end

  always_comb begin
    nStat = statReg;
    if (wrStat) nStat = ((regWrData & STAT_CLR_MASK) != 8'h00) ? 8'h00 : STAT_FORCED;
    if (wrCtrl && regWrData[CT_ABORT]) nStat[ST_ABORT] = 1'b1;
    if (seqDone) begin
      if (seqErr) nStat[ST_PERR] = 1'b1;
      else        nStat[ST_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      statReg <= '0;
      busy    <= 1'b0;
      startQ  <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= regWrData[CTRL_W-1:0];
      statReg <= nStat;
      startQ  <= launch;
      if (launch)       busy <= 1'b1;
      else if (seqDone) busy <= 1'b0;
      if (wrStat)
        irqQ <= ctrlReg[CT_IEN] && ((regWrData & STAT_CLR_MASK & ~statReg) != 8'h00);
      else if (seqDone)
        irqQ <= ctrlReg[CT_IEN] && ((nStat & STAT_CLR_MASK) != 8'h00);
    end
  end

  always_comb begin
    statusVal = statReg;
    statusVal[ST_BUSY] = busy;
  end
  assign ctrlVal  = ctrlReg;
  assign seqStart = startQ;
  assign irq      = irqQ;
endmodule

// File: rtl/smbHostData.sv
module smbHostData
  import smbhost_pkg::*;
#(
  parameter int BufDepth = DEF_BUF_DEPTH,
  localparam int IdxW = $clog2(BufDepth)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic [7:0]        statusVal,
  input  logic [CTRL_W-1:0] ctrlVal,
  output logic [7:0]        regRdData,
  output logic [7:0]        seqAddr,
  output logic [7:0]        seqCmd,
  output logic [7:0]        seqData0,
  output logic [7:0]        seqData1,
  input  logic              seqData0We,
  input  logic [7:0]        seqData0In,
  input  logic              seqData1We,
  input  logic [7:0]        seqData1In,
  input  logic              seqBufWe,
  input  logic [IdxW-1:0]   seqBufIdx,
  input  logic [7:0]        seqBufWrData,
  output logic [7:0]        seqBufRdData
);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(BufDepth - 1);

  logic [7:0] addrReg, cmdReg, d0Reg, d1Reg;
  logic [IdxW-1:0] idx;
  logic [7:0] bufMem [BufDepth];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      cmdReg  <= '0;
      d0Reg   <= '0;
      d1Reg   <= '0;
      idx     <= '0;
    end else begin
      if (strb.wrAddr) addrReg <= regWrData;
      if (strb.wrCmd)  cmdReg  <= regWrData;
      if (strb.wrD0)        d0Reg <= regWrData;
      else if (seqData0We)  d0Reg <= seqData0In;
      if (strb.wrD1)        d1Reg <= regWrData;
      else if (seqData1We)  d1Reg <= seqData1In;
      if (strb.idxClr)
        idx <= '0;
      else if (strb.bufWr || strb.bufRd)
        idx <= (idx == LastIdx) ? '0 : idx + 1'b1;
    end
  end

  // one register per buffer entry; host port wins over the sequencer
  for (genvar g = 0; g < BufDepth; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN)
        bufMem[g] <= '0;
      else if (strb.bufWr && idx == IdxW'(g))
        bufMem[g] <= regWrData;
      else if (seqBufWe && seqBufIdx == IdxW'(g))
        bufMem[g] <= seqBufWrData;
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_STAT: regRdData = statusVal;
      OFF_CTRL: regRdData = {{(8-CTRL_W){1'b0}}, ctrlVal};
      OFF_ADDR: regRdData = addrReg;
      OFF_D0:   regRdData = d0Reg;
      OFF_D1:   regRdData = d1Reg;
      OFF_CMD:  regRdData = cmdReg;
      OFF_BUF:  regRdData = bufMem[idx];
      default:  regRdData = 8'h00;
    endcase
  end

  assign seqAddr      = addrReg;
  assign seqCmd       = cmdReg;
  assign seqData0     = d0Reg;
  assign seqData1     = d1Reg;
  assign seqBufRdData = bufMem[seqBufIdx];
endmodule

// File: rtl/smbHostRegs.sv
module smbHostRegs
  import smbhost_pkg::*;
#(
  parameter int BufDepth = DEF_BUF_DEPTH,
  localparam int IdxW = $clog2(BufDepth)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [3:0]      regAddr,
  input  logic [7:0]      regWrData,
  output logic [7:0]      regRdData,
  output logic            irq,
  output logic            seqStart,
  output logic [2:0]      seqCycType,
  output logic [7:0]      seqAddr,
  output logic [7:0]      seqCmd,
  output logic [7:0]      seqData0,
  output logic [7:0]      seqData1,
  input  logic            seqDone,
  input  logic            seqErr,
  input  logic            seqData0We,
  input  logic [7:0]      seqData0In,
  input  logic            seqData1We,
  input  logic [7:0]      seqData1In,
  input  logic            seqBufWe,
  input  logic [IdxW-1:0] seqBufIdx,
  input  logic [7:0]      seqBufWrData,
  output logic [7:0]      seqBufRdData
);
  strobes_t strb;
  logic [7:0] statusVal;
  logic [CTRL_W-1:0] ctrlVal;

  smbHostCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .seqDone(seqDone), .seqErr(seqErr),
    .strb(strb), .statusVal(statusVal), .ctrlVal(ctrlVal),
    .seqStart(seqStart), .irq(irq)
  );

  smbHostData #(.BufDepth(BufDepth)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .regWrData(regWrData),
    .statusVal(statusVal), .ctrlVal(ctrlVal), .regRdData(regRdData),
    .seqAddr(seqAddr), .seqCmd(seqCmd), .seqData0(seqData0), .seqData1(seqData1),
    .seqData0We(seqData0We), .seqData0In(seqData0In),
    .seqData1We(seqData1We), .seqData1In(seqData1In),
    .seqBufWe(seqBufWe), .seqBufIdx(seqBufIdx), .seqBufWrData(seqBufWrData),
    .seqBufRdData(seqBufRdData)
  );

  assign seqCycType = ctrlVal[2:0];
endmodule

// File: rtl/smbHostRegs_chk.sv
module smbHostRegs_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [3:0] regAddr,
  input logic [7:0] regWrData,
  input logic       seqStart,
  input logic       seqDone,
  input logic       seqErr,
  input logic       irq,
  input logic [7:0] statusVal
);
  logic wrStat, wrCtrl;
  assign wrStat = regWrEn && regAddr == 4'h0;
  assign wrCtrl = regWrEn && regAddr == 4'h2;

  assert_start_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart);
  assert_busy_with_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> statusVal[3]);
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[3] && statusVal[3]) |=> !seqStart);
  assert_abort_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && regWrData[5]) |=> statusVal[0]);
  assert_done_ok_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && !seqErr && !regWrEn) |=> (statusVal[4] && !statusVal[3]));
  assert_done_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && seqErr && !regWrEn) |=> (statusVal[2] && !statusVal[3]));
  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && (regWrData & 8'h37) != 8'h00 && !seqDone) |=> (statusVal & 8'h37) == 8'h00);
  assert_stat_forced_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && (regWrData & 8'h37) == 8'h00 && !seqDone) |=> (statusVal & 8'h37) == 8'h10);
  assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && (regWrData & 8'h37 & ~statusVal) == 8'h00) |=> !irq);
endmodule

bind smbHostRegs smbHostRegs_chk chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .seqStart(seqStart), .seqDone(seqDone), .seqErr(seqErr), .irq(irq),
  .statusVal(statusVal)
);

// File: tb/smbHostRegs_tb_top.sv
`timescale 1ns/1ps
module smbHostRegs_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irq, seqStart;
  logic [2:0] seqCycType;
  logic [7:0] seqAddr, seqCmd, seqData0, seqData1;
  logic seqDone = 1'b0, seqErr = 1'b0;
  logic seqData0We = 1'b0, seqData1We = 1'b0, seqBufWe = 1'b0;
  logic [7:0] seqData0In = '0, seqData1In = '0, seqBufWrData = '0;
  logic [4:0] seqBufIdx = '0;
  logic [7:0] seqBufRdData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  smbHostRegs dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .seqStart(seqStart),
    .seqCycType(seqCycType), .seqAddr(seqAddr), .seqCmd(seqCmd), .seqData0(seqData0),
    .seqData1(seqData1), .seqDone(seqDone), .seqErr(seqErr),
    .seqData0We(seqData0We), .seqData0In(seqData0In),
    .seqData1We(seqData1We), .seqData1In(seqData1In),
    .seqBufWe(seqBufWe), .seqBufIdx(seqBufIdx), .seqBufWrData(seqBufWrData),
    .seqBufRdData(seqBufRdData)
  );

  // {write, offset, data, expected read}
  localparam int NVEC = 18;
  localparam logic [20:0] VECS [NVEC] = '{
    {1'b1, 4'h4, 8'hA5, 8'h00},  // R2 address
    {1'b0, 4'h4, 8'h00, 8'hA5},
    {1'b1, 4'h8, 8'h3C, 8'h00},  // R2 command
    {1'b0, 4'h8, 8'h00, 8'h3C},
    {1'b1, 4'h6, 8'h11, 8'h00},  // R2 data bytes
    {1'b1, 4'h7, 8'h22, 8'h00},
    {1'b0, 4'h6, 8'h00, 8'h11},
    {1'b0, 4'h7, 8'h00, 8'h22},
    {1'b0, 4'h3, 8'h00, 8'h00},  // R2 undefined offsets
    {1'b0, 4'hF, 8'h00, 8'h00},
    {1'b0, 4'h1, 8'h00, 8'h00},
    {1'b1, 4'h2, 8'hE2, 8'h00},  // R3 masked control, R4 abort
    {1'b0, 4'h2, 8'h00, 8'h02},
    {1'b0, 4'h0, 8'h00, 8'h01},
    {1'b1, 4'h0, 8'h00, 8'h00},  // R9 forced cycle-complete
    {1'b0, 4'h0, 8'h00, 8'h10},
    {1'b1, 4'h0, 8'h10, 8'h00},  // R9 clear
    {1'b0, 4'h0, 8'h00, 8'h00}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(logic [3:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    regAddr = a; #1;
    chk(req, regRdData, exp);
  endtask

  task automatic pop(logic [7:0] exp, string req);
    @(negedge clk);
    regAddr = 4'h9; regRdEn = 1'b1; #1;
    chk(req, regRdData, exp);
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic finish(logic err);
    @(negedge clk);
    seqDone = 1'b1; seqErr = err;
    @(posedge clk); #1;
    seqDone = 1'b0; seqErr = 1'b0;
    seqData0We = 1'b0; seqData1We = 1'b0; seqBufWe = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdChk(4'h0, 8'h00, "R1 status");
    rdChk(4'h2, 8'h00, "R1 control");
    rdChk(4'h4, 8'h00, "R1 address");
    rdChk(4'h6, 8'h00, "R1 data0");
    rdChk(4'h7, 8'h00, "R1 data1");
    rdChk(4'h8, 8'h00, "R1 command");
    rdChk(4'h9, 8'h00, "R1 buffer");
    chk("R1 irq", {7'h0, irq}, 8'h00);

    // register table walk (R2 R3 R4 R9)
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][20]) wr(VECS[i][19:16], VECS[i][15:8]);
      else rdChk(VECS[i][19:16], VECS[i][7:0], "R2/R3/R4/R9 table");
    end
    chk("R3 cycle type to sequencer", {5'h0, seqCycType}, 8'h02);
    chk("R10 irq low without enable", {7'h0, irq}, 8'h00);

    // R11 buffer fill with wrap: 33 writes, last overwrites entry 0
    for (int i = 0; i < 33; i++) wr(4'h9, 8'(i + 1));
    wr(4'h0, 8'h00);  // R9 index back to 0, status 0x10
    for (int i = 0; i < 32; i++) pop((i == 0) ? 8'd33 : 8'(i + 1), "R11 buffer read");
    pop(8'd33, "R11 index wrap on read");

    // R5 start
    wr(4'h0, 8'h37);
    rdChk(4'h0, 8'h00, "R9 clear all");
    wr(4'h2, 8'h1A);
    chk("R5 start pulse", {7'h0, seqStart}, 8'h01);
    chk("R3 cycle type", {5'h0, seqCycType}, 8'h02);
    chk("R12 address out", seqAddr, 8'hA5);
    chk("R12 command out", seqCmd, 8'h3C);
    chk("R12 data0 out", seqData0, 8'h11);
    chk("R12 data1 out", seqData1, 8'h22);
    rdChk(4'h0, 8'h08, "R5 busy");
    // R6 start while busy
    wr(4'h2, 8'h1A);
    chk("R6 no second pulse", {7'h0, seqStart}, 8'h00);
    rdChk(4'h0, 8'h08, "R6 still busy");
    chk("R5 pulse one cycle", {7'h0, seqStart}, 8'h00);

    // R7 R8 success with enabled interrupt and data return
    seqData0We = 1'b1; seqData0In = 8'h77; seqData1We = 1'b1; seqData1In = 8'h88;
    finish(1'b0);
    chk("R8 irq on done", {7'h0, irq}, 8'h01);
    rdChk(4'h0, 8'h10, "R7 complete, busy clear");
    rdChk(4'h6, 8'h77, "R12 data0 written");
    rdChk(4'h7, 8'h88, "R12 data1 written");

    // R10 status-write interrupt rule
    wr(4'h0, 8'h10);
    chk("R10 no new bit lowers irq", {7'h0, irq}, 8'h00);
    rdChk(4'h0, 8'h00, "R9 clear");
    wr(4'h0, 8'h04);
    chk("R10 new bit raises irq", {7'h0, irq}, 8'h01);
    wr(4'h0, 8'h08);
    chk("R10 non-clearable lowers irq", {7'h0, irq}, 8'h00);
    rdChk(4'h0, 8'h10, "R9 forced value");

    // R7 R8 error path without interrupt enable, sequencer buffer write
    wr(4'h2, 8'h08);
    chk("R5 start again", {7'h0, seqStart}, 8'h01);
    seqBufWe = 1'b1; seqBufIdx = 5'd5; seqBufWrData = 8'h5A;
    finish(1'b1);
    chk("R8 irq stays low without enable", {7'h0, irq}, 8'h00);
    rdChk(4'h0, 8'h14, "R7 error bit");
    #1 chk("R12 buffer read by sequencer", seqBufRdData, 8'h5A);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule